// File: doc/BRIEF.md
# Multi-Mode Buzzer Tone Generator

This block drives one buzzer pin with a square-wave tone. The tone is derived by integer division from a shared 12 kHz tone-base clock enable, and one of four pitches is picked by a 2-bit select. A 2-bit pattern select shapes the tone into one of four envelopes. The envelope timing is counted from a shared 1 kHz millisecond tick.

The four envelopes are: steady sound; a single 100 ms burst per start strobe; on/off gating at 10 Hz; and 10 Hz gating during the first half of every second with silence in the second half. The controlling CPU writes the enable, the two selects and the start strobe. When the block is disabled the pin rests low. A change of either select restarts every envelope and tone counter from zero, so a new setting always begins at a known phase.

The reset input is asynchronous and active low, and its release is synchronised inside the block. The output is registered, so it follows the internal tone phase and gate by one clock.

Top module: `buzz_tone_gen`

## Requirements
- R1: While reset is active, and for the two clocks after its release, `buzz_out` is low and all counters stay cleared.
- R2: `tone_sel` codes 0, 1, 2 and 3 give half-periods of 8, 6, 4 and 2 `tone_tick` pulses (0.75, 1, 1.5 and 3 kHz from a 12 kHz tick). The duty cycle is 50%, and the first half-period after a clear is low.
- R3: In pattern code 0 (steady) with the block enabled, `buzz_out` equals the tone phase of the previous clock.
- R4: In pattern code 1 (one-shot), a `shot_start` pulse opens the tone gate for exactly 100 `ms_tick` pulses. With no shot running, the output is low. A `shot_start` in any other pattern code has no effect.
- R5: A `shot_start` during a running shot reloads the full 100 ms length.
- R6: In pattern code 2 (pulsed), the gate is open for the first 50 ms of every 100 ms period and closed for the other 50 ms.
- R7: In pattern code 3 (framed), the 10 Hz gating of R6 applies during the first 500 ms of each 1000 ms frame, and the output is low for the remaining 500 ms.
- R8: When `buzz_en` is low, `buzz_out` is low from the next clock on. All envelope and tone counters are held at zero, so re-enabling starts from phase zero.
- R9: A change of `buzz_mode` or `tone_sel` from one clock to the next forces the output low for one clock and clears the tone, period, frame and shot counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tone_tick | input | 1 | 12 kHz tone-base clock enable |
| ms_tick | input | 1 | 1 kHz millisecond clock enable |
| buzz_en | input | 1 | Buzzer enable; low silences and clears |
| buzz_mode | input | 2 | Pattern: 0 steady, 1 one-shot, 2 pulsed, 3 framed |
| tone_sel | input | 2 | Pitch: 0 0.75 kHz, 1 1 kHz, 2 1.5 kHz, 3 3 kHz |
| shot_start | input | 1 | One-clock strobe starting or restarting a one-shot burst |
| buzz_out | output | 1 | Buzzer pin drive |

## Verification
The assertions check, on every clock:
- silence after disable;
- silence in the closed half of each pulsed period and in the quiet half of each framed second;
- the shot counter bound and its reload;
- steady-mode tracking of the tone phase;
- the tone counter range;
- the clearing that follows any select change.

Exact pitch, the 100 ms shot length measured end to end, and the alignment of bursts to the second boundary show up only in the bench's long scenarios. There, a behavioural reference model with millisecond and tick counters predicts the pin on every clock.

// File: rtl/buzz_pkg.sv
package buzz_pkg;
  typedef enum logic [1:0] {
    BZ_STEADY  = 2'd0,
    BZ_ONESHOT = 2'd1,
    BZ_PULSED  = 2'd2,
    BZ_FRAMED  = 2'd3
  } buzz_mode_e;

  localparam int NUM_TONES = 4;
endpackage

// File: rtl/buzz_cfg_watch.sv
module buzz_cfg_watch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_in,
  input  logic [1:0] sel_in,
  output logic       cfg_changed
);
  logic [1:0] mode_q, mode_d;
  logic [1:0] sel_q, sel_d;

  always_comb begin
    mode_d      = mode_in;
    sel_d       = sel_in;
    cfg_changed = (mode_in != mode_q) || (sel_in != sel_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'd0;
      sel_q  <= 2'd0;
    end else begin
      mode_q <= mode_d;
      sel_q  <= sel_d;
    end
  end
endmodule

// File: rtl/buzz_tone_div.sv
module buzz_tone_div #(
  parameter int                         HALF_W     = 8,
  parameter int                         N_TONES    = 4,
  parameter logic [N_TONES*HALF_W-1:0]  HALF_TABLE = {8'd2, 8'd4, 8'd6, 8'd8},
  localparam int                        SEL_W      = $clog2(N_TONES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic [SEL_W-1:0]  sel,
  output logic              phase,
  output logic [HALF_W-1:0] cnt,
  output logic [HALF_W-1:0] half
);
  logic [HALF_W-1:0] half_lut [N_TONES];
  logic [HALF_W-1:0] cnt_d;
  logic              phase_d;

  for (genvar g = 0; g < N_TONES; g++) begin : g_lut
    assign half_lut[g] = HALF_TABLE[g*HALF_W +: HALF_W];
  end

  assign half = half_lut[sel];

  always_comb begin
    cnt_d   = cnt;
    phase_d = phase;
    if (clr) begin
      cnt_d   = '0;
      phase_d = 1'b0;
    end else if (tick) begin
      if (cnt == half - HALF_W'(1)) begin
        cnt_d   = '0;
        phase_d = ~phase;
      end else begin
        cnt_d = cnt + HALF_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else begin
      cnt   <= cnt_d;
      phase <= phase_d;
    end
  end
endmodule

// File: rtl/buzz_envelope.sv
module buzz_envelope #(
  parameter int  GATE_PERIOD_MS = 100,
  parameter int  FRAME_SLOTS    = 10,
  parameter int  SHOT_MS        = 100,
  localparam int SUB_W          = $clog2(GATE_PERIOD_MS),
  localparam int SLOT_W         = $clog2(FRAME_SLOTS),
  localparam int SHOT_W         = $clog2(SHOT_MS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ms_tick,
  input  logic              arm,
  output logic [SUB_W-1:0]  sub_ms,
  output logic [SLOT_W-1:0] slot,
  output logic [SHOT_W-1:0] shot_left
);
  localparam logic [SUB_W-1:0]  SUB_LAST  = SUB_W'(GATE_PERIOD_MS - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(FRAME_SLOTS - 1);
  localparam logic [SHOT_W-1:0] SHOT_LOAD = SHOT_W'(SHOT_MS);

  logic [SUB_W-1:0]  sub_d;
  logic [SLOT_W-1:0] slot_d;
  logic [SHOT_W-1:0] shot_d;

  always_comb begin
    sub_d  = sub_ms;
    slot_d = slot;
    shot_d = shot_left;
    if (clr) begin
      sub_d  = '0;
      slot_d = '0;
      shot_d = '0;
    end else begin
      if (ms_tick) begin
        if (sub_ms == SUB_LAST) begin
          sub_d  = '0;
          slot_d = (slot == SLOT_LAST) ? '0 : slot + SLOT_W'(1);
        end else begin
          sub_d = sub_ms + SUB_W'(1);
        end
      end
      if (arm) begin
        shot_d = SHOT_LOAD;
      end else if (ms_tick && (shot_left != '0)) begin
        shot_d = shot_left - SHOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_ms    <= '0;
      slot      <= '0;
      shot_left <= '0;
    end else begin
      sub_ms    <= sub_d;
      slot      <= slot_d;
      shot_left <= shot_d;
    end
  end
endmodule

// File: rtl/buzz_tone_gen.sv
module buzz_tone_gen #(
  parameter int  HALF_W         = 8,
  parameter logic [4*HALF_W-1:0] HALF_TABLE = {8'd2, 8'd4, 8'd6, 8'd8},
  parameter int  GATE_PERIOD_MS = 100,
  parameter int  GATE_ON_MS     = 50,
  parameter int  FRAME_SLOTS    = 10,
  parameter int  FRAME_ON_SLOTS = 5,
  parameter int  SHOT_MS        = 100,
  localparam int SUB_W          = $clog2(GATE_PERIOD_MS),
  localparam int SLOT_W         = $clog2(FRAME_SLOTS),
  localparam int SHOT_W         = $clog2(SHOT_MS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tone_tick,
  input  logic       ms_tick,
  input  logic       buzz_en,
  input  logic [1:0] buzz_mode,
  input  logic [1:0] tone_sel,
  input  logic       shot_start,
  output logic       buzz_out
);
  import buzz_pkg::*;

  localparam logic [SUB_W-1:0]  ON_MS_V   = SUB_W'(GATE_ON_MS);
  localparam logic [SLOT_W-1:0] ON_SLOT_V = SLOT_W'(FRAME_ON_SLOTS);

  logic              rst_meta, rst_sync_n;
  logic              cfg_changed, clr, arm;
  logic              tone_phase, gate_open, buzz_d;
  logic [HALF_W-1:0] tone_cnt, tone_half;
  logic [SUB_W-1:0]  sub_ms;
  logic [SLOT_W-1:0] slot;
  logic [SHOT_W-1:0] shot_left;
  buzz_mode_e        mode_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  buzz_cfg_watch i_cfg (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .mode_in     (buzz_mode),
    .sel_in      (tone_sel),
    .cfg_changed (cfg_changed)
  );

  assign mode_e = buzz_mode_e'(buzz_mode);
  assign clr    = !buzz_en || cfg_changed;
  assign arm    = shot_start && (mode_e == BZ_ONESHOT);

  buzz_tone_div #(
    .HALF_W     (HALF_W),
    .N_TONES    (NUM_TONES),
    .HALF_TABLE (HALF_TABLE)
  ) i_tone (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (clr),
    .tick  (tone_tick),
    .sel   (tone_sel),
    .phase (tone_phase),
    .cnt   (tone_cnt),
    .half  (tone_half)
  );

  buzz_envelope #(
    .GATE_PERIOD_MS (GATE_PERIOD_MS),
    .FRAME_SLOTS    (FRAME_SLOTS),
    .SHOT_MS        (SHOT_MS)
  ) i_env (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr       (clr),
    .ms_tick   (ms_tick),
    .arm       (arm),
    .sub_ms    (sub_ms),
    .slot      (slot),
    .shot_left (shot_left)
  );

  always_comb begin
    unique case (mode_e)
      BZ_STEADY:  gate_open = 1'b1;
      BZ_ONESHOT: gate_open = (shot_left != '0);
      BZ_PULSED:  gate_open = (sub_ms < ON_MS_V);
      BZ_FRAMED:  gate_open = (sub_ms < ON_MS_V) && (slot < ON_SLOT_V);
      default:    gate_open = 1'b0;
    endcase
    buzz_d = buzz_en && !cfg_changed && tone_phase && gate_open;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) buzz_out <= 1'b0;
    else             buzz_out <= buzz_d;
  end
endmodule

// File: rtl/buzz_tone_gen_chk.sv
module buzz_tone_gen_chk #(
  parameter int  HALF_W         = 8,
  parameter int  GATE_PERIOD_MS = 100,
  parameter int  GATE_ON_MS     = 50,
  parameter int  FRAME_SLOTS    = 10,
  parameter int  FRAME_ON_SLOTS = 5,
  parameter int  SHOT_MS        = 100,
  localparam int SUB_W          = $clog2(GATE_PERIOD_MS),
  localparam int SLOT_W         = $clog2(FRAME_SLOTS),
  localparam int SHOT_W         = $clog2(SHOT_MS + 1)
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              buzz_en,
  input logic [1:0]        buzz_mode,
  input logic              shot_start,
  input logic              cfg_changed,
  input logic              tone_phase,
  input logic [HALF_W-1:0] tone_cnt,
  input logic [HALF_W-1:0] tone_half,
  input logic [SUB_W-1:0]  sub_ms,
  input logic [SLOT_W-1:0] slot,
  input logic [SHOT_W-1:0] shot_left,
  input logic              buzz_out
);
  localparam logic [SHOT_W-1:0] SHOT_V    = SHOT_W'(SHOT_MS);
  localparam logic [SUB_W-1:0]  ON_MS_V   = SUB_W'(GATE_ON_MS);
  localparam logic [SLOT_W-1:0] ON_SLOT_V = SLOT_W'(FRAME_ON_SLOTS);

  logic live;
  assign live = buzz_en && !cfg_changed;

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_sync_n |-> !buzz_out); // R1

  AST_HALF_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_changed |-> (tone_cnt < tone_half)); // R2

  AST_STEADY_TONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (live && buzz_mode == 2'd0) |=> (buzz_out == $past(tone_phase))); // R3

  AST_SHOT_LIMIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    shot_left <= SHOT_V); // R4

  AST_SHOT_RELOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (live && shot_start && buzz_mode == 2'd1) |=> (shot_left == SHOT_V)); // R5

  AST_PULSE_GAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (live && buzz_mode == 2'd2 && sub_ms >= ON_MS_V) |=> !buzz_out); // R6

  AST_FRAME_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (live && buzz_mode == 2'd3 && slot >= ON_SLOT_V) |=> !buzz_out); // R7

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !buzz_en |=> (!buzz_out && tone_cnt == '0 && shot_left == '0)); // R8

  AST_CLEAR_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_changed |=> (tone_cnt == '0 && sub_ms == '0 && slot == '0 && shot_left == '0)); // R9
endmodule

bind buzz_tone_gen buzz_tone_gen_chk #(
  .HALF_W         (HALF_W),
  .GATE_PERIOD_MS (GATE_PERIOD_MS),
  .GATE_ON_MS     (GATE_ON_MS),
  .FRAME_SLOTS    (FRAME_SLOTS),
  .FRAME_ON_SLOTS (FRAME_ON_SLOTS),
  .SHOT_MS        (SHOT_MS)
) i_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .buzz_en     (buzz_en),
  .buzz_mode   (buzz_mode),
  .shot_start  (shot_start),
  .cfg_changed (cfg_changed),
  .tone_phase  (tone_phase),
  .tone_cnt    (tone_cnt),
  .tone_half   (tone_half),
  .sub_ms      (sub_ms),
  .slot        (slot),
  .shot_left   (shot_left),
  .buzz_out    (buzz_out)
);

// File: tb/test_buzz_tone_gen.sv
`timescale 1ns/1ps
module test_buzz_tone_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tone_tick, ms_tick;
  logic       buzz_en;
  logic [1:0] buzz_mode, tone_sel;
  logic       shot_start;
  logic       buzz_out;

  always #2.5 clk = ~clk;

  buzz_tone_gen i_buzz_tone_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .tone_tick  (tone_tick),
    .ms_tick    (ms_tick),
    .buzz_en    (buzz_en),
    .buzz_mode  (buzz_mode),
    .tone_sel   (tone_sel),
    .shot_start (shot_start),
    .buzz_out   (buzz_out)
  );

  int    vectors = 0;
  int    fails   = 0;
  int    cyc     = 0;
  string cur_req = "R1";
  bit    done    = 0;

  // shared divider stand-in: tone tick every 2 clocks, ms tick every 24
  always @(negedge clk) begin
    cyc++;
    tone_tick <= (cyc % 2 == 0);
    ms_tick   <= (cyc % 24 == 5);
  end

  // behavioural reference model
  int m_rel, m_tc, m_ph, m_ms, m_shot;
  int m_pmode, m_psel;
  bit exp_buzz;

  function automatic int half_of(input int s);
    case (s)
      0: return 8;
      1: return 6;
      2: return 4;
      default: return 2;
    endcase
  endfunction

  function automatic bit gate_of(input int md, input int ms, input int shot);
    case (md)
      0: return 1'b1;
      1: return shot > 0;
      2: return (ms % 100) < 50;
      default: return ((ms % 100) < 50) && (ms < 500);
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rel = 0; m_tc = 0; m_ph = 0; m_ms = 0; m_shot = 0;
      m_pmode = 0; m_psel = 0; exp_buzz = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      bit change;
      change = (int'(buzz_mode) != m_pmode) || (int'(tone_sel) != m_psel);
      exp_buzz = buzz_en && !change && (m_ph == 1) &&
                 gate_of(int'(buzz_mode), m_ms, m_shot);
      if (!buzz_en || change) begin
        m_tc = 0; m_ph = 0; m_ms = 0; m_shot = 0;
      end else begin
        if (tone_tick) begin
          m_tc++;
          if (m_tc == half_of(int'(tone_sel))) begin
            m_tc = 0;
            m_ph = 1 - m_ph;
          end
        end
        if (shot_start && buzz_mode == 2'd1) m_shot = 100;
        else if (ms_tick && m_shot > 0)      m_shot--;
        if (ms_tick) m_ms = (m_ms + 1) % 1000;
      end
      m_pmode = int'(buzz_mode);
      m_psel  = int'(tone_sel);
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done && cyc > 1) begin
      vectors++;
      if (buzz_out !== exp_buzz) begin
        fails++;
        $display("FAIL %s cycle %0d buzz_out=%b expected=%b", cur_req, cyc, buzz_out, exp_buzz);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) shot_start = 1'b1;
    @(negedge clk) shot_start = 1'b0;
  endtask

  task automatic expect_low(input string req, input int n);
    repeat (n) begin
      @(negedge clk);
      vectors++;
      if (buzz_out !== 1'b0) begin
        fails++;
        $display("FAIL %s held-low check buzz_out=%b expected=0", req, buzz_out);
      end
    end
  endtask

  // watchdog
  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; buzz_en = 1'b0; buzz_mode = 2'd0; tone_sel = 2'd0; shot_start = 1'b0;
    tone_tick = 1'b0; ms_tick = 1'b0;
    // R1: output low while in reset
    cur_req = "R1";
    buzz_en = 1'b1;
    expect_low("R1", 6);
    @(negedge clk) rst_n = 1'b1;
    run(20);

    // R3 steady tone, R2 each pitch (each change also exercises R9)
    cur_req = "R3";
    run(600);
    for (int s = 1; s < 4; s++) begin
      cur_req = "R2";
      tone_sel = 2'(s);
      run(600);
    end

    // R8 disable mid-tone, then re-enable from phase zero
    cur_req = "R8";
    buzz_en = 1'b0;
    run(1);
    expect_low("R8", 300);
    buzz_en = 1'b1;
    run(300);

    // R4 one-shot: silent before start, 100 ms burst, silent after
    cur_req = "R4";
    tone_sel = 2'd1;
    buzz_mode = 2'd1;
    run(2);
    expect_low("R4", 400);
    pulse_start();
    run(2600);
    expect_low("R4", 300);

    // R5 restart during a shot
    cur_req = "R5";
    pulse_start();
    run(60 * 24);
    pulse_start();
    run(2700);

    // R4 start ignored outside one-shot
    cur_req = "R4";
    buzz_mode = 2'd2;
    pulse_start();
    run(200);

    // R6 pulsed gating
    cur_req = "R6";
    tone_sel = 2'd3;
    run(5000);

    // R7 framed bursts over more than one second
    cur_req = "R7";
    buzz_mode = 2'd3;
    tone_sel = 2'd0;
    run(26000);

    // R9 change pitch inside a framed burst
    cur_req = "R9";
    run(100 * 24);
    tone_sel = 2'd2;
    run(3000);
    buzz_mode = 2'd2;
    run(3000);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule